// File: doc/BRIEF.md
# Short Vector Register Index Sequencer

This block turns one short-vector floating-point operation into a run of scalar iterations. A start strobe loads the starting register indices of the destination and the two sources, together with a 3-bit length code and a 2-bit stride code. On every later cycle the block offers one iteration to the issue stage. Each iteration carries the three register indices and a flag that marks the final one. The issue stage answers with a ready signal, and a low ready means stall.

The register file is split into banks of eight. Each operand index steps by the selected stride and wraps inside its own bank, so the bank bits never change during an operation. A destination in bank 0 turns the whole operation into a single scalar iteration. A second source in bank 0 is a scalar operand and stays fixed while the other operands step. The arithmetic, hazard checks and the rest of instruction decode are outside this block.

Top module: `vsq_seq`

## Requirements
- R1: After reset, valid_o is low.
- R2: A start_i accepted at a clock edge raises valid_o from the next cycle on. The first iteration shows the loaded dst_i, src_a_i and src_b_i unchanged.
- R3: An operation runs for len_i+1 iterations. last_o is high only on the final one. With len_i = 0 there is exactly one iteration. After the final iteration is accepted without a new start, valid_o goes low.
- R4: Stride code 3 (binary 11) steps each index by two. Codes 0, 1 and 2 step by one.
- R5: Stepping changes only the low 3 bits of an index, modulo 8. The upper bits (the bank) stay as loaded, so an index starting at 7 goes 7, 0, 1, 2.
- R6: The destination and the first source step independently, each in its own bank, by the same stride.
- R7: If src_b_i lies in bank 0 (upper bits zero), src_b_o keeps its starting value on every iteration.
- R8: If dst_i lies in bank 0, the operation has one iteration whatever len_i holds.
- R9: While valid_o is high and ready_i is low, all outputs hold their values.
- R10: start_i is ignored while an operation is in progress. The one exception is the edge at which the final iteration is accepted. There a start is taken, and its first iteration follows in the next cycle with no gap.
- R11: With ready_i held high, iterations come out on consecutive cycles with valid_o high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a new vector operation |
| len_i | input | 3 | Length code, iterations minus one |
| stride_i | input | 2 | Stride code |
| dst_i | input | 5 | Starting destination index |
| src_a_i | input | 5 | Starting first source index |
| src_b_i | input | 5 | Starting second source index |
| ready_i | input | 1 | Issue stage accepts the current iteration |
| valid_o | output | 1 | An iteration is being offered |
| dst_o | output | 5 | Destination index of the current iteration |
| src_a_o | output | 5 | First source index of the current iteration |
| src_b_o | output | 5 | Second source index of the current iteration |
| last_o | output | 1 | Current iteration is the final one |

## Verification
Every output comes from a register. The first iteration of an operation is visible one cycle after the edge that takes start_i. Each later iteration is visible one cycle after the edge at which ready_i and valid_o are both high. The bench drives inputs and samples outputs on the falling edge, so each sample shows the state after the most recent rising edge. Before the next edge it compares that state with the iteration index kept by the bench. That index moves forward only when the bench itself drove ready_i high for that edge, so stall cycles are checked as repeats of the same iteration.

// File: rtl/vsq_pkg.sv
package vsq_pkg;
  localparam int unsigned NUM_OPS = 3;
  typedef enum logic [1:0] {OP_DST = 2'd0, OP_SRC_A = 2'd1, OP_SRC_B = 2'd2} op_e;
endpackage

// File: rtl/vsq_cfg.sv
module vsq_cfg #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned LEN_W  = 3,
  parameter int unsigned STR_W  = 2
) (
  input  logic [LEN_W-1:0]  len_i,
  input  logic [STR_W-1:0]  stride_i,
  input  logic [IDX_W-1:0]  dst_i,
  input  logic [IDX_W-1:0]  src_b_i,
  output logic [LEN_W-1:0]  eff_len_o,
  output logic [BANK_W-1:0] step_o,
  output logic              hold_b_o
);
  localparam int unsigned SEL_W = IDX_W - BANK_W;

  logic dst_scalar;
  assign dst_scalar = (dst_i[IDX_W-1:BANK_W] == SEL_W'(0));
  assign eff_len_o  = dst_scalar ? '0 : len_i;
  // only the all-ones code doubles the step; other codes are reserved -> 1
  assign step_o     = (stride_i == '1) ? BANK_W'(2) : BANK_W'(1);
  assign hold_b_o   = (src_b_i[IDX_W-1:BANK_W] == SEL_W'(0));
endmodule

// File: rtl/vsq_idx_step.sv
module vsq_idx_step #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [IDX_W-1:0]  load_idx_i,
  input  logic [BANK_W-1:0] step_i,
  input  logic              hold_i,
  input  logic              adv_i,
  output logic [IDX_W-1:0]  idx_o
);
  logic [IDX_W-1:0]  idx_q;
  logic [BANK_W-1:0] step_q;
  logic              hold_q;
  logic [BANK_W-1:0] lo_next;

  assign lo_next = idx_q[BANK_W-1:0] + step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      step_q <= '0;
      hold_q <= 1'b0;
    end else if (load_i) begin
      idx_q  <= load_idx_i;
      step_q <= step_i;
      hold_q <= hold_i;
    end else if (adv_i && !hold_q) begin
      idx_q  <= {idx_q[IDX_W-1:BANK_W], lo_next};
    end
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/vsq_iter_ctr.sv
module vsq_iter_ctr #(
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             accept_i,
  output logic             valid_o,
  output logic             last_o
);
  logic [LEN_W-1:0] rem_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      rem_q   <= len_i;
      valid_q <= 1'b1;
    end else if (accept_i) begin
      if (rem_q == '0) valid_q <= 1'b0;
      else             rem_q   <= rem_q - LEN_W'(1);
    end
  end

  assign valid_o = valid_q;
  assign last_o  = valid_q && (rem_q == '0);
endmodule

// File: rtl/vsq_seq.sv
module vsq_seq #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned LEN_W  = 3,
  parameter int unsigned STR_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [STR_W-1:0] stride_i,
  input  logic [IDX_W-1:0] dst_i,
  input  logic [IDX_W-1:0] src_a_i,
  input  logic [IDX_W-1:0] src_b_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] dst_o,
  output logic [IDX_W-1:0] src_a_o,
  output logic [IDX_W-1:0] src_b_o,
  output logic             last_o
);
  import vsq_pkg::*;

  logic [LEN_W-1:0]  eff_len;
  logic [BANK_W-1:0] step;
  logic              hold_b;
  logic              valid, last, accept, load, adv;
  logic [IDX_W-1:0]  load_idx [NUM_OPS];
  logic              hold     [NUM_OPS];
  logic [IDX_W-1:0]  idx      [NUM_OPS];

  vsq_cfg #(.IDX_W(IDX_W), .BANK_W(BANK_W), .LEN_W(LEN_W), .STR_W(STR_W)) u_cfg (
    .len_i    (len_i),
    .stride_i (stride_i),
    .dst_i    (dst_i),
    .src_b_i  (src_b_i),
    .eff_len_o(eff_len),
    .step_o   (step),
    .hold_b_o (hold_b)
  );

  assign accept = valid && ready_i;
  // new start only when idle or on the edge that retires the final iteration
  assign load   = start_i && (!valid || (accept && last));
  assign adv    = accept && !last;

  vsq_iter_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .len_i   (eff_len),
    .accept_i(accept),
    .valid_o (valid),
    .last_o  (last)
  );

  assign load_idx[OP_DST]   = dst_i;
  assign load_idx[OP_SRC_A] = src_a_i;
  assign load_idx[OP_SRC_B] = src_b_i;
  assign hold[OP_DST]       = 1'b0;
  assign hold[OP_SRC_A]     = 1'b0;
  assign hold[OP_SRC_B]     = hold_b;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    vsq_idx_step #(.IDX_W(IDX_W), .BANK_W(BANK_W)) u_step (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .load_idx_i(load_idx[g]),
      .step_i    (step),
      .hold_i    (hold[g]),
      .adv_i     (adv),
      .idx_o     (idx[g])
    );
  end

  assign valid_o = valid;
  assign last_o  = last;
  assign dst_o   = idx[OP_DST];
  assign src_a_o = idx[OP_SRC_A];
  assign src_b_o = idx[OP_SRC_B];
endmodule

// File: rtl/vsq_seq_chk.sv
module vsq_seq_chk #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned LEN_W  = 3,
  parameter int unsigned STR_W  = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [LEN_W-1:0] len_i,
  input logic [STR_W-1:0] stride_i,
  input logic [IDX_W-1:0] dst_i,
  input logic [IDX_W-1:0] src_a_i,
  input logic [IDX_W-1:0] src_b_i,
  input logic             ready_i,
  input logic             valid_o,
  input logic [IDX_W-1:0] dst_o,
  input logic [IDX_W-1:0] src_a_o,
  input logic [IDX_W-1:0] src_b_o,
  input logic             last_o
);
  localparam int unsigned SEL_W = IDX_W - BANK_W;

  logic step_cyc;
  assign step_cyc = valid_o && ready_i && !last_o;

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(dst_o) && $stable(src_a_o) && $stable(src_b_o) && $stable(last_o)); // R9

  AST_BANK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_cyc |=> dst_o[IDX_W-1:BANK_W] == $past(dst_o[IDX_W-1:BANK_W]) && src_a_o[IDX_W-1:BANK_W] == $past(src_a_o[IDX_W-1:BANK_W])); // R5

  AST_STEP_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_cyc |=> (dst_o[BANK_W-1:0] == $past(dst_o[BANK_W-1:0]) + BANK_W'(1)) || (dst_o[BANK_W-1:0] == $past(dst_o[BANK_W-1:0]) + BANK_W'(2))); // R4

  AST_SRCB_SCALAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_cyc && src_b_o[IDX_W-1:BANK_W] == SEL_W'(0) |=> src_b_o == $past(src_b_o)); // R7

  AST_DST_SCALAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) && dst_o[IDX_W-1:BANK_W] == SEL_W'(0) |-> last_o); // R8

  AST_BUSY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !(ready_i && last_o) |=> valid_o); // R11

  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && last_o && !start_i |=> !valid_o); // R3
endmodule

bind vsq_seq vsq_seq_chk #(.IDX_W(IDX_W), .BANK_W(BANK_W), .LEN_W(LEN_W), .STR_W(STR_W)) u_chk (.*);

// File: tb/vsq_seq_tb.sv
`timescale 1ns/1ps
module vsq_seq_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] len_i = '0;
  logic [1:0] stride_i = '0;
  logic [4:0] dst_i = '0, src_a_i = '0, src_b_i = '0;
  logic       ready_i = 1'b0;
  logic       valid_o, last_o;
  logic [4:0] dst_o, src_a_o, src_b_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // next vector for back-to-back chaining
  logic [2:0] nx_len;
  logic [1:0] nx_str;
  logic [4:0] nx_d, nx_a, nx_b;

  always #2.5 clk_i = ~clk_i;

  vsq_seq u_dut (.*);

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_idx(logic [4:0] s, int k, int st, bit hold);
    logic [2:0] lo;
    if (hold) return s;
    lo = s[2:0] + 3'(k * st);
    return {s[4:3], lo};
  endfunction

  task automatic drive_start(logic [2:0] l, logic [1:0] s, logic [4:0] d, logic [4:0] a, logic [4:0] b);
    start_i = 1'b1; len_i = l; stride_i = s; dst_i = d; src_a_i = a; src_b_i = b;
  endtask

  // stall: 0 none, 1 stall every other cycle; ign: junk start mid-run; chain: start nx_* on last accept
  task automatic run_vec(string tag, logic [2:0] l, logic [1:0] s, logic [4:0] d, logic [4:0] a,
                         logic [4:0] b, int stall, bit ign, bit chain, bit do_start);
    int n, st, k, cyc;
    bit hb, ign_done;
    n  = (d[4:3] == 2'b00) ? 1 : int'(l) + 1;
    st = (s == 2'b11) ? 2 : 1;
    hb = (b[4:3] == 2'b00);
    ign_done = 0;
    if (do_start) begin
      drive_start(l, s, d, a, b);
      ready_i = 1'b1;
      @(negedge clk_i);
    end
    k = 0; cyc = 0;
    while (k < n && cyc < 100) begin
      start_i = 1'b0;
      chk(tag, int'(valid_o), 1, "valid_o");
      chk(tag, int'(dst_o),   int'(exp_idx(d, k, st, 0)),  "dst_o");
      chk(tag, int'(src_a_o), int'(exp_idx(a, k, st, 0)),  "src_a_o");
      chk(tag, int'(src_b_o), int'(exp_idx(b, k, st, hb)), "src_b_o");
      chk(tag, int'(last_o),  (k == n - 1) ? 1 : 0,        "last_o");
      ready_i = (stall != 0 && (cyc % 2 == 0)) ? 1'b0 : 1'b1;
      if (ign && k == 1 && !ign_done) begin
        drive_start(3'd0, 2'b11, 5'd9, 5'd17, 5'd30);  // must be ignored
        ign_done = 1;
      end
      if (chain && ready_i && k == n - 1) drive_start(nx_len, nx_str, nx_d, nx_a, nx_b);
      if (ready_i) k++;
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0;
    if (k < n) chk(tag, k, n, "iterations completed");
    if (!chain) chk(tag, int'(valid_o), 0, "valid_o after final");
  endtask

  task automatic t_reset;
    chk("R1", int'(valid_o), 0, "valid_o in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", int'(valid_o), 0, "valid_o after reset");
  endtask

  task automatic t_basic;  // R2 R3 R5 R6 R11: 7 wraps to 0,1,2
    run_vec("R5", 3'd3, 2'b00, 5'd16, 5'd7, 5'd25, 0, 0, 0, 1);
  endtask

  task automatic t_stride2;  // R4
    run_vec("R4", 3'd5, 2'b11, 5'd14, 5'd23, 5'd9, 0, 0, 0, 1);
  endtask

  task automatic t_reserved;  // R4 codes 1 and 2
    run_vec("R4", 3'd2, 2'b01, 5'd30, 5'd13, 5'd21, 0, 0, 0, 1);
    run_vec("R4", 3'd2, 2'b10, 5'd31, 5'd12, 5'd20, 0, 0, 0, 1);
  endtask

  task automatic t_len0;  // R3
    run_vec("R3", 3'd0, 2'b00, 5'd18, 5'd26, 5'd10, 0, 0, 0, 1);
  endtask

  task automatic t_full;  // R6 R11 long run, stride 2 wrap twice
    run_vec("R6", 3'd7, 2'b11, 5'd9, 5'd31, 5'd16, 0, 0, 0, 1);
  endtask

  task automatic t_srcb_scalar;  // R7
    run_vec("R7", 3'd4, 2'b00, 5'd20, 5'd28, 5'd3, 0, 0, 0, 1);
  endtask

  task automatic t_dst_scalar;  // R8
    run_vec("R8", 3'd7, 2'b11, 5'd2, 5'd12, 5'd25, 0, 0, 0, 1);
  endtask

  task automatic t_stall;  // R9
    run_vec("R9", 3'd3, 2'b11, 5'd11, 5'd19, 5'd27, 1, 0, 0, 1);
  endtask

  task automatic t_ignore;  // R10
    run_vec("R10", 3'd3, 2'b00, 5'd24, 5'd8, 5'd16, 1, 1, 0, 1);
  endtask

  task automatic t_chain;  // R10 back-to-back
    nx_len = 3'd2; nx_str = 2'b11; nx_d = 5'd15; nx_a = 5'd6; nx_b = 5'd4;
    run_vec("R10", 3'd1, 2'b00, 5'd8, 5'd16, 5'd24, 0, 0, 1, 1);
    run_vec("R10", nx_len, nx_str, nx_d, nx_a, nx_b, 0, 0, 0, 0);
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_stride2();
    t_reserved();
    t_len0();
    t_full();
    t_srcb_scalar();
    t_dst_scalar();
    t_stall();
    t_ignore();
    t_chain();
    repeat (2) @(negedge clk_i);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule